// File: doc/BRIEF.md
# Block-Synchronous Stub Packer

This block gathers coincidence stub addresses from a group of front-end readout chips on every bunch crossing and packs them into frames of constant length and constant latency. Each chip offers up to three stub lanes per crossing. Each lane carries a valid flag and a 7-bit strip address, and the all-ones address is a reserved no-hit code. The block collects eight consecutive crossings into one block and keeps at most fourteen stubs from it. Each kept stub is tagged with its crossing index and its chip index.

During the block that follows, the frame is sent out as one 40-bit word per crossing, eight words in all. A start marker accompanies the first word. The frame position and the delay do not depend on how many stubs arrived, so a downstream receiver can stay locked to the block boundary without any handshake. When a block holds more stubs than the cap allows, the earliest stubs are kept and a flag in the frame header is raised.

Top module: `stub_block_packer`

## Requirements
- R1: After reset, and through the whole first block, `out_valid` and `out_start` are 0 and `out_word` is all zeros.
- R2: From the second block onward, `out_valid` stays 1. `out_start` is 1 only on the first crossing of each block, which is every eighth cycle, and is never high on two consecutive cycles.
- R3: The stubs sampled on crossings 0..7 of a block appear in the frame sent out on crossings 0..7 of the next block. Word w of the frame is emitted on crossing w.
- R4: Word w carries frame bits [40w+39:40w]. Frame bit 0 is the overflow flag, bits 4:1 hold the kept-stub count, bits 7:5 are zero and bits above 189 are zero. Slot i sits at bits [8+13i+12 : 8+13i]. A slot holds the address in bits 6:0, the chip index in bits 9:7 and the crossing index in bits 12:10.
- R5: Slots are filled in this order: crossing index first, then chip index, then lane index within the chip, with all indices ascending.
- R6: No more than 14 stubs are kept per block. When more accepted stubs arrive, the extra ones are dropped, the count reads 14 and the overflow flag is 1.
- R7: A lane whose valid flag is 0, or whose address equals 7'h7F, is ignored. Such a lane takes no slot, does not change the count and does not set overflow.
- R8: An unfilled slot reads crossing 0, chip 0 and address 7'h7F.
- R9: Every block starts from an empty state. The count and the overflow flag of one block do not depend on any earlier block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock; one edge per bunch crossing |
| rst_n | input | 1 | Active-low synchronous reset; the first edge after release is crossing 0 |
| in_vld | input | 24 | Per-lane valid flags, lane index = chip*3 + lane |
| in_addr | input | 168 | Per-lane 7-bit addresses, lane k at bits [7k+6:7k] |
| out_word | output | 40 | Current frame word |
| out_start | output | 1 | High with word 0 of each frame |
| out_valid | output | 1 | High once a complete frame is available |

## Verification
On every cycle the assertions check the framing: the crossing counter wraps after its last crossing, a start marker follows every block end, markers are isolated, and valid stays up once it has risen. Inside the accumulator they check that overflow only appears with a full count and that the count never shrinks within a block. The slot order, the treatment of the no-hit code and of invalid lanes, the filling of unused slots, and the exact bit layout of each word can only be shown by the bench's scenarios. The bench compares every output word with a frame it builds itself from sparse, dense, overflowing and masked stimulus.

// File: rtl/stub_pkg.sv
package stub_pkg;
    localparam int DEF_CHIPS  = 8;   // front-end chips per half module
    localparam int DEF_LANES  = 3;   // stub lanes per chip and crossing
    localparam int DEF_ADDR_W = 7;   // strip address width
    localparam int DEF_BLOCK  = 8;   // crossings per block
    localparam int DEF_CAP    = 14;  // stubs kept per block
    localparam int DEF_OUT_W  = 40;  // output bits per crossing
    localparam int HDR_W      = 8;   // frame header width
endpackage

// File: rtl/stub_xing_timer.sv
module stub_xing_timer #(
    parameter int BLOCK = stub_pkg::DEF_BLOCK,
    localparam int BX_W = $clog2(BLOCK)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [BX_W-1:0] bx,
    output logic            last
);
    typedef struct packed {
        logic [BX_W-1:0] bx;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        last  = (tmr_q.bx == BX_W'(BLOCK - 1));
        tmr_d.bx = last ? '0 : tmr_q.bx + 1'b1;
        bx    = tmr_q.bx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: the crossing index wraps to 0 right after the last crossing
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (bx == '0));
endmodule

// File: rtl/stub_accum.sv
module stub_accum #(
    parameter int CHIPS  = stub_pkg::DEF_CHIPS,
    parameter int LANES  = stub_pkg::DEF_LANES,
    parameter int ADDR_W = stub_pkg::DEF_ADDR_W,
    parameter int BLOCK  = stub_pkg::DEF_BLOCK,
    parameter int CAP    = stub_pkg::DEF_CAP,
    localparam int NLANE  = CHIPS * LANES,
    localparam int BX_W   = $clog2(BLOCK),
    localparam int CH_W   = $clog2(CHIPS),
    localparam int SLOT_W = BX_W + CH_W + ADDR_W,
    localparam int CNT_W  = $clog2(CAP + 1),
    localparam int SI_W   = $clog2(CAP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BX_W-1:0]         bx,
    input  logic [NLANE-1:0]        in_vld,
    input  logic [NLANE*ADDR_W-1:0] in_addr,
    output logic [CAP*SLOT_W-1:0]   slots_nxt,
    output logic [CNT_W-1:0]        cnt_nxt,
    output logic                    ovf_nxt
);
    localparam logic [ADDR_W-1:0] NOHIT = '1;
    localparam logic [CNT_W-1:0]  CAP_C = CNT_W'(CAP);

    typedef struct packed {
        logic [CAP-1:0][SLOT_W-1:0] slot;
        logic [CNT_W-1:0]           cnt;
        logic                       ovf;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [ADDR_W-1:0] lane_addr;

    always_comb begin
        // a new block rebases on an empty list with every slot holding no-hit
        if (bx == '0) begin
            for (int i = 0; i < CAP; i++)
                acc_d.slot[i] = {{(BX_W + CH_W){1'b0}}, NOHIT};
            acc_d.cnt = '0;
            acc_d.ovf = 1'b0;
        end else begin
            acc_d = acc_q;
        end
        lane_addr = '0;
        // earlier crossings already hold the lower slots; append chip then lane
        for (int c = 0; c < CHIPS; c++) begin
            for (int s = 0; s < LANES; s++) begin
                lane_addr = in_addr[(c*LANES + s)*ADDR_W +: ADDR_W];
                if (in_vld[c*LANES + s] && lane_addr != NOHIT) begin
                    if (acc_d.cnt < CAP_C) begin
                        acc_d.slot[SI_W'(acc_d.cnt)] = {bx, CH_W'(c), lane_addr};
                        acc_d.cnt = acc_d.cnt + 1'b1;
                    end else begin
                        acc_d.ovf = 1'b1;
                    end
                end
            end
        end
        slots_nxt = acc_d.slot;
        cnt_nxt   = acc_d.cnt;
        ovf_nxt   = acc_d.ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R6: overflow is only ever recorded once the list is full
    assert_ovf_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.ovf |-> (acc_q.cnt == CAP_C));

    // R9: within a block the count never shrinks; it restarts only at crossing 1
    assert_cnt_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bx != BX_W'(1)) |-> (acc_q.cnt >= $past(acc_q.cnt)));
endmodule

// File: rtl/stub_frame_fmt.sv
module stub_frame_fmt #(
    parameter int SLOT_W  = 13,
    parameter int CAP     = stub_pkg::DEF_CAP,
    parameter int CNT_W   = 4,
    parameter int FRAME_W = 320,
    localparam int HDR_W  = stub_pkg::HDR_W
) (
    input  logic [CAP*SLOT_W-1:0] slots,
    input  logic [CNT_W-1:0]      cnt,
    input  logic                  ovf,
    output logic [FRAME_W-1:0]    frame
);
    always_comb begin
        frame = '0;
        frame[0] = ovf;
        frame[CNT_W:1] = cnt;
        frame[HDR_W +: CAP*SLOT_W] = slots;
    end
endmodule

// File: rtl/stub_block_packer.sv
module stub_block_packer #(
    parameter int CHIPS  = stub_pkg::DEF_CHIPS,
    parameter int LANES  = stub_pkg::DEF_LANES,
    parameter int ADDR_W = stub_pkg::DEF_ADDR_W,
    parameter int BLOCK  = stub_pkg::DEF_BLOCK,
    parameter int CAP    = stub_pkg::DEF_CAP,
    parameter int OUT_W  = stub_pkg::DEF_OUT_W,
    localparam int NLANE   = CHIPS * LANES,
    localparam int BX_W    = $clog2(BLOCK),
    localparam int CH_W    = $clog2(CHIPS),
    localparam int SLOT_W  = BX_W + CH_W + ADDR_W,
    localparam int CNT_W   = $clog2(CAP + 1),
    localparam int FRAME_W = BLOCK * OUT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLANE-1:0]        in_vld,
    input  logic [NLANE*ADDR_W-1:0] in_addr,
    output logic [OUT_W-1:0]        out_word,
    output logic                    out_start,
    output logic                    out_valid
);
    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               fv;
    } shd_t;

    shd_t shd_d, shd_q;

    logic [BX_W-1:0]       bx;
    logic                  last;
    logic [CAP*SLOT_W-1:0] slots_nxt;
    logic [CNT_W-1:0]      cnt_nxt;
    logic                  ovf_nxt;
    logic [FRAME_W-1:0]    frame_nxt;

    stub_xing_timer #(.BLOCK(BLOCK)) u_tmr (
        .clk(clk), .rst_n(rst_n), .bx(bx), .last(last)
    );

    stub_accum #(
        .CHIPS(CHIPS), .LANES(LANES), .ADDR_W(ADDR_W),
        .BLOCK(BLOCK), .CAP(CAP)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .bx(bx),
        .in_vld(in_vld), .in_addr(in_addr),
        .slots_nxt(slots_nxt), .cnt_nxt(cnt_nxt), .ovf_nxt(ovf_nxt)
    );

    stub_frame_fmt #(
        .SLOT_W(SLOT_W), .CAP(CAP), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
    ) u_fmt (
        .slots(slots_nxt), .cnt(cnt_nxt), .ovf(ovf_nxt), .frame(frame_nxt)
    );

    always_comb begin
        shd_d = shd_q;
        if (last) begin
            shd_d.frame = frame_nxt;
            shd_d.fv    = 1'b1;
        end
        out_word  = shd_q.frame[int'(bx)*OUT_W +: OUT_W];
        out_start = shd_q.fv && (bx == '0);
        out_valid = shd_q.fv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    // R2: every completed block is followed by a start marker
    assert_start_after_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> out_start);

    // R2: start markers are isolated
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |=> !out_start);

    // R2: once frames flow, valid never drops
    assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
endmodule

// File: tb/stub_block_packer_test.sv
module stub_block_packer_test;
    localparam int NL = 24;
    localparam int AW = 7;
    localparam int FW = 320;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   in_vld = '0;
    logic [NL*AW-1:0] in_addr = '0;
    logic [39:0]     out_word;
    logic            out_start;
    logic            out_valid;

    always #10 clk = ~clk;

    stub_block_packer uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_addr(in_addr),
        .out_word(out_word), .out_start(out_start), .out_valid(out_valid)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct packed {
        logic [NL-1:0] mask;
        logic [6:0]    base;
        logic [3:0]    cnt;
        logic          ovf;
    } ent_t;

    localparam ent_t TBL [5] = '{
        '{24'h000000, 7'd0,  4'd0,  1'b0},
        '{24'h000001, 7'd10, 4'd8,  1'b0},
        '{24'h800000, 7'd40, 4'd8,  1'b0},
        '{24'h000003, 7'd3,  4'd14, 1'b1},
        '{24'h000100, 7'd90, 4'd8,  1'b0}
    };

    logic [NL-1:0]    cur_v [8];
    logic [NL*AW-1:0] cur_a [8];
    logic [FW-1:0]    exp_f;
    bit               have = 0;
    logic [3:0]       p_cnt;
    logic             p_ovf;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [FW-1:0] model();
        logic [FW-1:0] f = '0;
        int n = 0;
        logic ov = 1'b0;
        logic [6:0] ad;
        for (int i = 0; i < 14; i++) f[8 + 13*i +: 13] = {6'd0, 7'h7F};
        for (int j = 0; j < 8; j++)
            for (int c = 0; c < 8; c++)
                for (int s = 0; s < 3; s++) begin
                    ad = cur_a[j][(c*3 + s)*AW +: AW];
                    if (cur_v[j][c*3 + s] && ad != 7'h7F) begin
                        if (n < 14) begin
                            f[8 + 13*n +: 13] = {3'(j), 3'(c), ad};
                            n++;
                        end else ov = 1'b1;
                    end
                end
        f[0] = ov;
        f[4:1] = 4'(n);
        return f;
    endfunction

    task automatic clear_stim();
        for (int j = 0; j < 8; j++) begin
            cur_v[j] = '0;
            cur_a[j] = '0;
        end
    endtask

    task automatic fill(input ent_t e);
        for (int j = 0; j < 8; j++)
            for (int i = 0; i < NL; i++) begin
                cur_v[j][i] = e.mask[i];
                cur_a[j][i*AW +: AW] = 7'((int'(e.base) + 5*j + i) % 127);
            end
    endtask

    // called at a negedge whose next posedge is crossing 0; checks the previous frame meanwhile
    task automatic drive_block(input logic [3:0] ecnt, input logic eovf);
        for (int j = 0; j < 8; j++) begin
            in_vld  = cur_v[j];
            in_addr = cur_a[j];
            if (!have) begin
                check(out_valid == 1'b0, "R1 valid before first frame", 64'(out_valid), 0);
                check(out_start == 1'b0, "R1 start before first frame", 64'(out_start), 0);
                check(out_word == '0, "R1 word before first frame", 64'(out_word), 0);
            end else begin
                check(out_valid == 1'b1, "R2 valid", 64'(out_valid), 1);
                check(out_start == (j == 0), "R2 start marker", 64'(out_start), 64'(j == 0));
                check(out_word == exp_f[40*j +: 40], "R3/R4/R5/R8 frame word",
                      64'(out_word), 64'(exp_f[40*j +: 40]));
                if (j == 0) begin
                    check(out_word[4:1] == p_cnt, "R6/R7 kept count", 64'(out_word[4:1]), 64'(p_cnt));
                    check(out_word[0] == p_ovf, "R6 R9 overflow flag", 64'(out_word[0]), 64'(p_ovf));
                end
            end
            @(negedge clk);
        end
        exp_f = model();
        p_cnt = ecnt;
        p_ovf = eovf;
        have  = 1;
    endtask

    initial begin
        clear_stim();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_start == 1'b0 && out_word == '0, "R1 in reset",
              64'({out_valid, out_start}), 0);
        rst_n = 1'b1;

        // table walk: each pattern block is followed by an idle block
        for (int k = 0; k < 5; k++) begin
            fill(TBL[k]);
            drive_block(TBL[k].cnt, TBL[k].ovf);
            clear_stim();
            drive_block(4'd0, 1'b0);
        end

        // R7: no-hit code on valid lanes and invalid lanes with real addresses
        clear_stim();
        cur_v[3] = '1;
        for (int i = 0; i < NL; i++) cur_a[3][i*AW +: AW] = 7'h7F;
        cur_a[3][10*AW +: AW] = 7'd5;
        for (int i = 0; i < NL; i++) cur_a[5][i*AW +: AW] = 7'd9;
        drive_block(4'd1, 1'b0);

        // R6: every lane on every crossing, earliest stubs kept
        for (int j = 0; j < 8; j++) begin
            cur_v[j] = '1;
            for (int i = 0; i < NL; i++) cur_a[j][i*AW +: AW] = 7'((20 + i + j) % 127);
        end
        drive_block(4'd14, 1'b1);

        // R9: back-to-back block with a single late stub starts clean
        clear_stim();
        cur_v[7][6*3 + 1] = 1'b1;
        cur_a[7][(6*3 + 1)*AW +: AW] = 7'd33;
        drive_block(4'd1, 1'b0);

        clear_stim();
        drive_block(4'd0, 1'b0);
        drive_block(4'd0, 1'b0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule